// File: doc/BRIEF.md
# Receive Hash Steering and Status Writer

This block sits in the receive path of a multi-queue Ethernet controller, after the parser and the hash engine. For each received packet it takes a 4-bit layer-3/4 class code, a 32-bit hash that has already been computed, and a one-cycle strobe. It decides from the configuration enables whether this packet's hash may be used. When it may, the block uses the low byte of the hash to index an external lookup table and takes the table entry as the receive DMA channel.

It also builds the two descriptor status words that carry the hash back to software. One word holds the hash itself. The other holds the packet class, a hash-valid flag and a layer-4 indication. All results are registered and appear one cycle after the strobe, together with an output strobe. The lookup table lives in the configuration block. This block reads it through a combinational read port: it drives the index and gets the entry back in the same cycle.

Top module: `rss_steer`

## Requirements
- R1: `out_valid` is high in the cycle after each cycle in which `pkt_valid` is high, and low otherwise; all results are registered on that edge.
- R2: When `cfg_rss_en` is 0, no packet is hashed, whatever its class or the other enables.
- R3: With `cfg_rss_en` set, class code 1 (IPv4 TCP) is hashed when `cfg_tcp4_en` or `cfg_ip_en` is set. Class code 2 (IPv4 UDP) is hashed when `cfg_udp4_en` or `cfg_ip_en` is set.
- R4: With `cfg_rss_en` set, class codes 3 (IPv4 ICMP), 9 (IPv6 TCP), 10 (IPv6 UDP) and 11 (IPv6 ICMP) are hashed exactly when `cfg_ip_en` is set. Every other code (0, 4 to 8, 12 to 15) is never hashed.
- R5: `lut_idx` always equals `pkt_hash[7:0]`. For a hashed packet, `out_chan` is the 4-bit `lut_chan` value read in the strobe cycle.
- R6: For a packet that is not hashed, `out_chan` is 0, `out_hash_ok` is 0 and `out_desc1` is 0.
- R7: For a hashed packet, `out_hash_ok` is 1 and `out_desc1` equals the 32-bit input hash.
- R8: `out_desc3` carries the class code in bits 23:20 and `out_hash_ok` in bit 26; all other bits are 0.
- R9: `out_l4` is 1 for class codes 1, 2, 9 and 10 and 0 for every other code, whether or not the packet is hashed.
- R10: After reset, `out_valid`, `out_chan`, `out_hash_ok`, `out_l4`, `out_desc1` and `out_desc3` are all 0.
- R11: In cycles without a strobe, the result outputs keep their last values, even when the packet inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_rss_en | input | 1 | Global hashing enable |
| cfg_ip_en | input | 1 | Enable hashing for all IP classes |
| cfg_tcp4_en | input | 1 | Enable hashing for IPv4 TCP |
| cfg_udp4_en | input | 1 | Enable hashing for IPv4 UDP |
| pkt_valid | input | 1 | Packet strobe, one cycle per packet |
| pkt_type | input | 4 | Layer-3/4 class code |
| pkt_hash | input | 32 | Precomputed packet hash |
| lut_idx | output | 8 | Lookup-table read index |
| lut_chan | input | 4 | Lookup-table entry (channel) for `lut_idx` |
| out_valid | output | 1 | Result strobe |
| out_chan | output | 4 | Selected receive DMA channel |
| out_hash_ok | output | 1 | Hash is valid for this packet |
| out_l4 | output | 1 | Packet class is TCP or UDP |
| out_desc1 | output | 32 | Descriptor word carrying the hash |
| out_desc3 | output | 32 | Descriptor status word with class and hash-valid flag |

## Verification
Two things can land in the same cycle: a change of the configuration enables and the arrival of a packet strobe. The permit decision must use the enables present in the strobe cycle, not the ones from the cycle before. The bench changes the enables and the packet inputs together at one falling edge. It then judges the registered result against a model that is fed those same-cycle enables. It also sends packets on back-to-back cycles, so that the output register reloads on consecutive edges with no idle cycle between.

// File: rtl/rss_steer_pkg.sv
package rss_steer_pkg;

  localparam int CLS_W = 4;

  localparam logic [CLS_W-1:0] CLS_V4_TCP  = 4'd1;
  localparam logic [CLS_W-1:0] CLS_V4_UDP  = 4'd2;
  localparam logic [CLS_W-1:0] CLS_V4_ICMP = 4'd3;
  localparam logic [CLS_W-1:0] CLS_V6_TCP  = 4'd9;
  localparam logic [CLS_W-1:0] CLS_V6_UDP  = 4'd10;
  localparam logic [CLS_W-1:0] CLS_V6_ICMP = 4'd11;

  typedef struct packed {
    logic all_en;
    logic ip_en;
    logic tcp4_en;
    logic udp4_en;
  } steer_cfg_t;

  // True for a class code that carries a TCP or UDP payload
  function automatic logic cls_is_l4(input logic [CLS_W-1:0] c);
    return (c == CLS_V4_TCP) || (c == CLS_V4_UDP) ||
           (c == CLS_V6_TCP) || (c == CLS_V6_UDP);
  endfunction

  // Decide whether the hash of a packet of class c may be used
  function automatic logic cls_permit(input logic [CLS_W-1:0] c,
                                      input steer_cfg_t cfg);
    logic ok;
    unique case (c)
      CLS_V4_TCP:  ok = cfg.tcp4_en | cfg.ip_en;
      CLS_V4_UDP:  ok = cfg.udp4_en | cfg.ip_en;
      CLS_V4_ICMP,
      CLS_V6_TCP,
      CLS_V6_UDP,
      CLS_V6_ICMP: ok = cfg.ip_en;
      default:     ok = 1'b0;
    endcase
    return ok & cfg.all_en;
  endfunction

endpackage

// File: rtl/rss_class.sv
module rss_class
  import rss_steer_pkg::*;
(
  input  logic [CLS_W-1:0] cls,
  input  steer_cfg_t       cfg,
  output logic             hash_go,
  output logic             l4
);

  always_comb begin
    hash_go = cls_permit(cls, cfg);
    l4      = cls_is_l4(cls);
  end

endmodule

// File: rtl/rss_status_pack.sv
module rss_status_pack
  import rss_steer_pkg::*;
#(
  parameter int HASH_W    = 32,
  parameter int DESC_W    = 32,
  parameter int CLS_LSB   = 20,
  parameter int VALID_BIT = 26
) (
  input  logic              hash_go,
  input  logic [CLS_W-1:0]  cls,
  input  logic [HASH_W-1:0] hash,
  output logic [HASH_W-1:0] word1,
  output logic [DESC_W-1:0] word3
);

  always_comb begin
    word1 = hash_go ? hash : '0;
    word3 = '0;
    word3[CLS_LSB +: CLS_W] = cls;
    word3[VALID_BIT]        = hash_go;
  end

endmodule

// File: rtl/rss_steer.sv
module rss_steer
  import rss_steer_pkg::*;
#(
  parameter int HASH_W    = 32,
  parameter int IDX_W     = 8,
  parameter int CHAN_W    = 4,
  parameter int DESC_W    = 32,
  parameter int CLS_LSB   = 20,
  parameter int VALID_BIT = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_rss_en,
  input  logic              cfg_ip_en,
  input  logic              cfg_tcp4_en,
  input  logic              cfg_udp4_en,
  input  logic              pkt_valid,
  input  logic [CLS_W-1:0]  pkt_type,
  input  logic [HASH_W-1:0] pkt_hash,
  output logic [IDX_W-1:0]  lut_idx,
  input  logic [CHAN_W-1:0] lut_chan,
  output logic              out_valid,
  output logic [CHAN_W-1:0] out_chan,
  output logic              out_hash_ok,
  output logic              out_l4,
  output logic [HASH_W-1:0] out_desc1,
  output logic [DESC_W-1:0] out_desc3
);

  steer_cfg_t        cfg;
  logic              hash_go;
  logic              l4_now;
  logic [CHAN_W-1:0] chan_now;
  logic [HASH_W-1:0] word1_now;
  logic [DESC_W-1:0] word3_now;

  assign cfg = '{all_en: cfg_rss_en, ip_en: cfg_ip_en,
                 tcp4_en: cfg_tcp4_en, udp4_en: cfg_udp4_en};

  assign lut_idx  = pkt_hash[IDX_W-1:0];
  assign chan_now = hash_go ? lut_chan : '0;

  rss_class u_class (
    .cls     (pkt_type),
    .cfg     (cfg),
    .hash_go (hash_go),
    .l4      (l4_now)
  );

  rss_status_pack #(
    .HASH_W    (HASH_W),
    .DESC_W    (DESC_W),
    .CLS_LSB   (CLS_LSB),
    .VALID_BIT (VALID_BIT)
  ) u_pack (
    .hash_go (hash_go),
    .cls     (pkt_type),
    .hash    (pkt_hash),
    .word1   (word1_now),
    .word3   (word3_now)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_chan    <= '0;
      out_hash_ok <= 1'b0;
      out_l4      <= 1'b0;
      out_desc1   <= '0;
      out_desc3   <= '0;
    end else begin
      out_valid <= pkt_valid;
      if (pkt_valid) begin
        out_chan    <= chan_now;
        out_hash_ok <= hash_go;
        out_l4      <= l4_now;
        out_desc1   <= word1_now;
        out_desc3   <= word3_now;
      end
    end
  end

endmodule

// File: rtl/rss_steer_chk.sv
module rss_steer_chk
  import rss_steer_pkg::*;
#(
  parameter int HASH_W    = 32,
  parameter int IDX_W     = 8,
  parameter int CHAN_W    = 4,
  parameter int DESC_W    = 32,
  parameter int CLS_LSB   = 20,
  parameter int VALID_BIT = 26
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_rss_en,
  input logic              pkt_valid,
  input logic [CLS_W-1:0]  pkt_type,
  input logic [HASH_W-1:0] pkt_hash,
  input logic [IDX_W-1:0]  lut_idx,
  input logic [CHAN_W-1:0] lut_chan,
  input logic              hash_go,
  input logic              out_valid,
  input logic [CHAN_W-1:0] out_chan,
  input logic              out_hash_ok,
  input logic [HASH_W-1:0] out_desc1,
  input logic [DESC_W-1:0] out_desc3
);

  a_r1_strobe_on: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |=> out_valid);

  a_r1_strobe_off: assert property (@(posedge clk) disable iff (!rst_n)
    !pkt_valid |=> !out_valid);

  a_r2_global_off: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && !cfg_rss_en) |=> (!out_hash_ok && out_chan == '0));

  a_r5_index: assert property (@(posedge clk) disable iff (!rst_n)
    lut_idx == pkt_hash[IDX_W-1:0]);

  a_r5_channel: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && hash_go) |=> (out_chan == $past(lut_chan)));

  a_r6_unhashed: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_hash_ok) |-> (out_chan == '0 && out_desc1 == '0));

  a_r7_hash_word: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && hash_go) |=> (out_hash_ok && out_desc1 == $past(pkt_hash)));

  a_r8_status_word: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |=> (out_desc3[CLS_LSB +: CLS_W] == $past(pkt_type) &&
                   out_desc3[VALID_BIT] == out_hash_ok));

  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !pkt_valid |=> ($stable(out_chan) && $stable(out_desc1) &&
                    $stable(out_desc3)));

endmodule

bind rss_steer rss_steer_chk #(
  .HASH_W    (HASH_W),
  .IDX_W     (IDX_W),
  .CHAN_W    (CHAN_W),
  .DESC_W    (DESC_W),
  .CLS_LSB   (CLS_LSB),
  .VALID_BIT (VALID_BIT)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_rss_en  (cfg_rss_en),
  .pkt_valid   (pkt_valid),
  .pkt_type    (pkt_type),
  .pkt_hash    (pkt_hash),
  .lut_idx     (lut_idx),
  .lut_chan    (lut_chan),
  .hash_go     (hash_go),
  .out_valid   (out_valid),
  .out_chan    (out_chan),
  .out_hash_ok (out_hash_ok),
  .out_desc1   (out_desc1),
  .out_desc3   (out_desc3)
);

// File: tb/rss_steer_test.sv
module rss_steer_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_rss_en = 1'b0, cfg_ip_en = 1'b0, cfg_tcp4_en = 1'b0, cfg_udp4_en = 1'b0;
  logic        pkt_valid = 1'b0;
  logic [3:0]  pkt_type = '0;
  logic [31:0] pkt_hash = '0;
  logic [7:0]  lut_idx;
  logic [3:0]  lut_chan;
  logic        out_valid, out_hash_ok, out_l4;
  logic [3:0]  out_chan;
  logic [31:0] out_desc1, out_desc3;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  // Table model: an arbitrary fold of the index into a channel
  assign lut_chan = lut_idx[3:0] ^ {lut_idx[6:4], lut_idx[7]};

  rss_steer uut (
    .clk(clk), .rst_n(rst_n),
    .cfg_rss_en(cfg_rss_en), .cfg_ip_en(cfg_ip_en),
    .cfg_tcp4_en(cfg_tcp4_en), .cfg_udp4_en(cfg_udp4_en),
    .pkt_valid(pkt_valid), .pkt_type(pkt_type), .pkt_hash(pkt_hash),
    .lut_idx(lut_idx), .lut_chan(lut_chan),
    .out_valid(out_valid), .out_chan(out_chan), .out_hash_ok(out_hash_ok),
    .out_l4(out_l4), .out_desc1(out_desc1), .out_desc3(out_desc3)
  );

  function automatic logic [3:0] model_chan(input logic [31:0] h);
    logic [7:0] i;
    i = h[7:0];
    return i[3:0] ^ {i[6:4], i[7]};
  endfunction

  function automatic bit model_go(input logic [3:0] t, input bit g, input bit ip,
                                  input bit tcp, input bit udp);
    if (!g) return 1'b0;
    if (t == 4'd1) return tcp || ip;
    if (t == 4'd2) return udp || ip;
    if (t == 4'd3 || t == 4'd9 || t == 4'd10 || t == 4'd11) return ip;
    return 1'b0;
  endfunction

  function automatic bit model_l4(input logic [3:0] t);
    return (t == 4'd1) || (t == 4'd2) || (t == 4'd9) || (t == 4'd10);
  endfunction

  task automatic cmp(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one packet at a falling edge, check the registered result after the next rise
  task automatic send(input logic [3:0] t, input logic [31:0] h,
                      input bit g, input bit ip, input bit tcp, input bit udp,
                      input string req);
    bit go;
    logic [31:0] d3;
    @(negedge clk);
    cfg_rss_en = g; cfg_ip_en = ip; cfg_tcp4_en = tcp; cfg_udp4_en = udp;
    pkt_type = t; pkt_hash = h; pkt_valid = 1'b1;
    #1;
    cmp({req, " R5 index"}, {24'd0, lut_idx}, {24'd0, h[7:0]});
    @(posedge clk); #2;
    go = model_go(t, g, ip, tcp, udp);
    d3 = '0; d3[23:20] = t; d3[26] = go;
    cmp({req, " R1 valid"}, {31'd0, out_valid}, 32'd1);
    cmp({req, " hash_ok"}, {31'd0, out_hash_ok}, {31'd0, go});
    cmp({req, " chan"}, {28'd0, out_chan}, go ? {28'd0, model_chan(h)} : 32'd0);
    cmp({req, " R7 desc1"}, out_desc1, go ? h : 32'd0);
    cmp({req, " R8 desc3"}, out_desc3, d3);
    cmp({req, " R9 l4"}, {31'd0, out_l4}, {31'd0, model_l4(t)});
  endtask

  task automatic idle();
    @(negedge clk);
    pkt_valid = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    cmp("R10 valid", {31'd0, out_valid}, 32'd0);
    cmp("R10 chan", {28'd0, out_chan}, 32'd0);
    cmp("R10 flags", {30'd0, out_hash_ok, out_l4}, 32'd0);
    cmp("R10 desc1", out_desc1, 32'd0);
    cmp("R10 desc3", out_desc3, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_global_off();
    for (int t = 0; t < 16; t++) send(4'(t), 32'hA5A5_0000 + 32'(t * 37), 1'b0, 1'b1, 1'b1, 1'b1, "R2 off");
    idle();
  endtask

  task automatic t_tcp_udp_fallback();
    for (int m = 0; m < 8; m++) begin
      send(4'd1, 32'h1357_9B00 + 32'(m * 19), 1'b1, m[0], m[1], m[2], "R3 v4tcp");
      send(4'd2, 32'h2468_AC00 + 32'(m * 23), 1'b1, m[0], m[1], m[2], "R3 v4udp");
    end
    idle();
  endtask

  task automatic t_other_classes();
    for (int t = 0; t < 16; t++) begin
      send(4'(t), 32'hDEAD_0000 + 32'(t * 53), 1'b1, 1'b1, 1'b0, 1'b0, "R4 ip on");
      send(4'(t), 32'hBEEF_0000 + 32'(t * 61), 1'b1, 1'b0, 1'b1, 1'b1, "R4 ip off");
    end
    idle();
  endtask

  task automatic t_lut_sweep();
    for (int i = 0; i < 256; i += 17) send(4'd10, {24'hC0FFEE, 8'(i)}, 1'b1, 1'b1, 1'b0, 1'b0, "R5 sweep");
    idle();
  endtask

  task automatic t_unhashed_after_hashed();
    send(4'd9, 32'hFFFF_FFFF, 1'b1, 1'b1, 1'b0, 1'b0, "R6 prior");
    send(4'd9, 32'h7777_7777, 1'b1, 1'b0, 1'b0, 1'b0, "R6 cleared");
    idle();
  endtask

  task automatic t_hold();
    logic [3:0] c; logic [31:0] d1, d3;
    send(4'd1, 32'h0BAD_F00D, 1'b1, 1'b0, 1'b1, 1'b0, "R11 load");
    c = out_chan; d1 = out_desc1; d3 = out_desc3;
    idle();
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      pkt_type = 4'(k + 2); pkt_hash = 32'h1111_1111 * 32'(k + 1); cfg_ip_en = k[0];
      @(posedge clk); #2;
      cmp("R11 no strobe", {31'd0, out_valid}, 32'd0);
      cmp("R11 chan held", {28'd0, out_chan}, {28'd0, c});
      cmp("R11 desc1 held", out_desc1, d1);
      cmp("R11 desc3 held", out_desc3, d3);
    end
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_global_off();
    t_tcp_udp_fallback();
    t_other_classes();
    t_lut_sweep();
    t_unhashed_after_hashed();
    t_hold();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule